// File: doc/BRIEF.md
# Circular Audio Sample Buffer Engine

This block streams 8-bit audio samples in both directions between a shared 16-bit word memory and a byte-wide codec port. Software sets up a four-word header in memory at an address aligned to four words. It then writes that address into the control port. The engine reads the header once and from then on acts on each sample tick without ever waiting for software. On each tick it exchanges one byte with the codec: one byte goes out and one comes in.

Output words carry two samples, high byte first. Each output word is read on the even phase of a tick pair and complemented before it is sent. Incoming bytes are packed two to a word. The packed word is complemented and written to the input area on every even phase. The input address is the output pointer plus a displacement, taken modulo 65536. On every odd phase the engine writes its updated output pointer back into the header, so that software can follow its progress. A write of an odd address to the control port requests a stop, which takes effect at the next tick.

States: `ST_IDLE` waits for a start write. `ST_HDR` reads the four header words. `ST_RUN` waits for a tick. `ST_FETCH` issues the output word read. `ST_EVEN_XFER` sends the high byte and stores the packed input word. `ST_ODD_XFER` sends the low byte and writes back the pointer.

Transitions:
- start: `ST_IDLE` → `ST_HDR`.
- header done: `ST_HDR` → `ST_RUN`.
- stop tick: `ST_RUN` → `ST_IDLE`.
- even tick: `ST_RUN` → `ST_FETCH` → `ST_EVEN_XFER` → `ST_RUN`.
- odd tick: `ST_RUN` → `ST_ODD_XFER` → `ST_RUN`.
- not-ready tick: `ST_RUN` stays in `ST_RUN`.

Top module: `aud_ring_engine`

## Requirements
- R1: A control write whose address has bits [1:0] = 00, made while idle, starts the engine. The engine reads header words at base+0, base+1, base+2 and base+3 (word 0 = first output offset, word 1 = last output offset, word 2 = next pointer, word 3 = input displacement). It then runs with the even phase, the pointer taken from word 2 and the input accumulator cleared. A control write with bits [1:0] = 10 is ignored, and a start write made while running is ignored.
- R2: On an even-phase tick with the codec ready, the engine reads the word at base+pointer and sends the complement of its bits [15:8] as one codec strobe.
- R3: After each even-phase exchange the pointer becomes the first offset if it equalled the last offset; otherwise it increments by one, modulo 65536.
- R4: On an odd-phase tick with the codec ready, the engine sends the complement of bits [7:0] of the word fetched on the previous even phase. This phase makes no memory read.
- R5: On each even-phase exchange the engine writes the complement of the input accumulator to base + ((pointer + displacement) mod 65536). The pointer used is its value before the R3 update, and all address sums are taken modulo 65536.
- R6: Each exchange shifts the received byte into accumulator bits [7:0] and moves the previous bits [7:0] to bits [15:8]. The store of R5 uses the accumulator as it was before that exchange's byte.
- R7: On each odd-phase exchange the engine writes the current (already updated) pointer to base+2.
- R8: The first input word stored after a start is 16'hFFFF, because the accumulator was cleared.
- R9: A control write with address bit 0 = 1, made while running, makes the next tick perform no exchange and no memory access and returns the engine to idle. No later tick causes activity.
- R10: A tick with the codec not ready causes no strobe and no memory access, and leaves the phase unchanged.
- R11: The header is read only at start. Later changes to header words in memory do not alter the first offset, last offset or displacement in use.
- R12: Every ready tick while running produces exactly one strobe cycle, and each strobe cycle coincides with exactly one memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_addr | input | AW | Base address (start) or odd value (stop) |
| tick | input | 1 | One-cycle sample period pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 2*SW | Memory write data |
| mem_rdata | input | 2*SW | Read data, one cycle after a read request |
| cdc_ready | input | 1 | Codec ready, sampled with the tick |
| cdc_strobe | output | 1 | One-cycle byte exchange strobe |
| cdc_tx | output | SW | Byte sent to the codec |
| cdc_rx | input | SW | Byte received from the codec, taken at the strobe |

## Verification
A wrong phase bit would show up on the next ready tick. The engine would either read memory where it should not, or send the low byte where the high byte was expected, so the error appears within one sample period. A pointer that wraps wrongly, or a header word that is reloaded, would send bytes from the wrong word within one tick pair. It would also leave the wrong value at base+2 after the next odd phase. An accumulator fault would appear as a wrong input word at the next even store, and a stop that is not honoured would show as a strobe after the stop tick.

// File: rtl/aud_pkg.sv
package aud_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_RUN,
        ST_FETCH,
        ST_EVEN_XFER,
        ST_ODD_XFER
    } aud_state_e;

    localparam int HDR_WORDS = 4;
    localparam int HDR_IW    = $clog2(HDR_WORDS + 1);
endpackage

// File: rtl/aud_seq.sv
module aud_seq
    import aud_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              tick,
    input  logic              cdc_ready,
    output logic [HDR_IW-1:0] hdr_idx,
    output logic              hdr_rd,
    output logic              hdr_cap,
    output logic              fetch_rd,
    output logic              xfer_even,
    output logic              xfer_odd,
    output logic              clear
);
    aud_state_e state, state_nx;
    logic       phase;
    logic       stop_pend;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_idx   <= '0;
            phase     <= 1'b0;
            stop_pend <= 1'b0;
        end else if (state == ST_IDLE) begin
            hdr_idx   <= '0;
            phase     <= 1'b0;
            stop_pend <= 1'b0;
        end else begin
            if (state == ST_HDR)       hdr_idx   <= hdr_idx + 1'b1;
            if (stop_req)              stop_pend <= 1'b1;
            if (state == ST_EVEN_XFER) phase     <= 1'b1;
            if (state == ST_ODD_XFER)  phase     <= 1'b0;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_req) state_nx = ST_HDR;
            ST_HDR:       if (hdr_idx == HDR_IW'(HDR_WORDS)) state_nx = ST_RUN;
            ST_RUN: begin
                if (tick) begin
                    if (stop_pend)      state_nx = ST_IDLE;
                    else if (cdc_ready) state_nx = phase ? ST_ODD_XFER : ST_FETCH;
                end
            end
            ST_FETCH:     state_nx = ST_EVEN_XFER;
            ST_EVEN_XFER: state_nx = ST_RUN;
            ST_ODD_XFER:  state_nx = ST_RUN;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        hdr_rd    = 1'b0;
        hdr_cap   = 1'b0;
        fetch_rd  = 1'b0;
        xfer_even = 1'b0;
        xfer_odd  = 1'b0;
        clear     = 1'b0;
        unique case (state)
            ST_IDLE:      clear = start_req;
            ST_HDR: begin
                hdr_rd  = (hdr_idx < HDR_IW'(HDR_WORDS));
                hdr_cap = (hdr_idx != '0);
            end
            ST_RUN:       ;
            ST_FETCH:     fetch_rd  = 1'b1;
            ST_EVEN_XFER: xfer_even = 1'b1;
            ST_ODD_XFER:  xfer_odd  = 1'b1;
            default:      ;
        endcase
    end

    // R9: a pending stop ends the run at the next tick
    a_r9_stop_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && stop_pend) |=> (state == ST_IDLE));

    // R10: a tick without codec ready leaves the engine waiting, phase kept
    a_r10_not_ready_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && !stop_pend && !cdc_ready)
            |=> (state == ST_RUN && $stable(phase)));

    // R4: ready ticks alternate between even and odd exchanges
    a_r4_phase_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && tick && !stop_pend && cdc_ready)
            |=> ((state == ST_ODD_XFER) == $past(phase)));

    // R1: header loading always ends in the running state
    a_r1_hdr_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR && hdr_idx == HDR_IW'(HDR_WORDS)) |=> (state == ST_RUN));
endmodule

// File: rtl/aud_hdr.sv
module aud_hdr
    import aud_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_cap,
    input  logic [HDR_IW-1:0] hdr_idx,
    input  logic [AW-1:0]     rdata,
    input  logic              advance,
    output logic [AW-1:0]     ptr,
    output logic [AW-1:0]     in_off
);
    logic [AW-1:0] first_q, last_q, disp_q;

    // header word k arrives when the load counter reads k+1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            disp_q  <= '0;
            ptr     <= '0;
        end else if (hdr_cap) begin
            unique case (hdr_idx)
                HDR_IW'(1): first_q <= rdata;
                HDR_IW'(2): last_q  <= rdata;
                HDR_IW'(3): ptr     <= rdata;
                HDR_IW'(4): disp_q  <= rdata;
                default:    ;
            endcase
        end else if (advance) begin
            ptr <= (ptr == last_q) ? first_q : ptr + AW'(1);
        end
    end

    assign in_off = ptr + disp_q;

    // R3: wrap to the first offset after the last one
    a_r3_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !hdr_cap && ptr == last_q) |=> (ptr == $past(first_q)));

    // R3: otherwise step by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !hdr_cap && ptr != last_q) |=> (ptr == $past(ptr) + AW'(1)));

    // R11: header values change only while being loaded
    a_r11_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_cap |=> ($stable(first_q) && $stable(last_q) && $stable(disp_q)));
endmodule

// File: rtl/aud_smp.sv
module aud_smp #(
    parameter int SW = 8,
    localparam int DW = 2 * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          xfer_even,
    input  logic          xfer_odd,
    input  logic [DW-1:0] rdata,
    input  logic [SW-1:0] rx,
    output logic [SW-1:0] tx,
    output logic [DW-1:0] store_word
);
    logic [SW-1:0] olo_q;
    logic [DW-1:0] acc_q;
    logic          xfer;

    assign xfer = xfer_even | xfer_odd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            olo_q <= '0;
            acc_q <= '0;
        end else begin
            if (clear)          acc_q <= '0;
            else if (xfer)      acc_q <= {acc_q[SW-1:0], rx};
            if (xfer_even)      olo_q <= ~rdata[SW-1:0];
        end
    end

    always_comb begin
        tx = xfer_even ? ~rdata[DW-1:SW] : olo_q;
    end

    assign store_word = ~acc_q;

    // R6: received byte enters low, old low byte moves high
    a_r6_pack_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !clear) |=> (acc_q[SW-1:0] == $past(rx) &&
                              acc_q[DW-1:SW] == $past(acc_q[SW-1:0])));
endmodule

// File: rtl/aud_ring_engine.sv
module aud_ring_engine
    import aud_pkg::*;
#(
    parameter int AW = 16,
    parameter int SW = 8,
    localparam int DW = 2 * SW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [AW-1:0] ctl_addr,
    input  logic          tick,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          cdc_ready,
    output logic          cdc_strobe,
    output logic [SW-1:0] cdc_tx,
    input  logic [SW-1:0] cdc_rx
);
    logic [HDR_IW-1:0] hdr_idx;
    logic hdr_rd, hdr_cap, fetch_rd, xfer_even, xfer_odd, clear;
    logic start_req, stop_req;
    logic [AW-1:0] base_q, ptr, in_off;
    logic [DW-1:0] store_word;

    assign start_req = ctl_wr && (ctl_addr[1:0] == 2'b00);
    assign stop_req  = ctl_wr && ctl_addr[0];

    always_ff @(posedge clk) begin
        if (!rst_n)     base_q <= '0;
        else if (clear) base_q <= ctl_addr;
    end

    aud_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .tick(tick), .cdc_ready(cdc_ready), .hdr_idx(hdr_idx), .hdr_rd(hdr_rd),
        .hdr_cap(hdr_cap), .fetch_rd(fetch_rd), .xfer_even(xfer_even),
        .xfer_odd(xfer_odd), .clear(clear)
    );

    aud_hdr #(.AW(AW)) u_hdr (
        .clk(clk), .rst_n(rst_n), .hdr_cap(hdr_cap), .hdr_idx(hdr_idx),
        .rdata(mem_rdata[AW-1:0]), .advance(xfer_even), .ptr(ptr), .in_off(in_off)
    );

    aud_smp #(.SW(SW)) u_smp (
        .clk(clk), .rst_n(rst_n), .clear(clear), .xfer_even(xfer_even),
        .xfer_odd(xfer_odd), .rdata(mem_rdata), .rx(cdc_rx), .tx(cdc_tx),
        .store_word(store_word)
    );

    always_comb begin
        mem_req   = hdr_rd | fetch_rd | xfer_even | xfer_odd;
        mem_we    = xfer_even | xfer_odd;
        mem_addr  = base_q;
        mem_wdata = '0;
        if (hdr_rd)         mem_addr = base_q + AW'(hdr_idx);
        else if (fetch_rd)  mem_addr = base_q + ptr;
        else if (xfer_even) begin
            mem_addr  = base_q + in_off;
            mem_wdata = store_word;
        end else if (xfer_odd) begin
            mem_addr  = base_q + AW'(2);
            mem_wdata = DW'(ptr);
        end
    end

    assign cdc_strobe = xfer_even | xfer_odd;

    // R12: each exchange strobe is paired with one memory write
    a_r12_strobe_writes: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_strobe |-> (mem_req && mem_we));

    // R12: strobe lasts a single cycle
    a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        cdc_strobe |=> !cdc_strobe);

    // R2: an output word read is followed by its exchange
    a_r2_fetch_then_send: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !hdr_rd) |=> cdc_strobe);
endmodule

// File: tb/tb_aud_ring_engine.sv
`timescale 1ns/1ps
module tb_aud_ring_engine;
    localparam int AW = 16;
    localparam int SW = 8;
    localparam int DW = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 1'b0, tick = 1'b0, cdc_ready = 1'b0;
    logic [AW-1:0] ctl_addr = '0;
    logic mem_req, mem_we, cdc_strobe;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [SW-1:0] cdc_tx, cdc_rx = '0;

    always #4 clk = ~clk;

    aud_ring_engine #(.AW(AW), .SW(SW)) dut (.*);

    logic [DW-1:0] mem [1024];
    logic bw_en = 1'b0;
    logic [9:0] bw_addr = '0;
    logic [DW-1:0] bw_data = '0;

    always @(posedge clk) begin
        if (bw_en) mem[bw_addr] <= bw_data;
        if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_req) mem_rdata <= mem[mem_addr[9:0]];
    end

    int scnt = 0, wcnt = 0, rcnt = 0;
    logic [SW-1:0] last_tx = '0;
    always @(negedge clk) begin
        if (cdc_strobe) begin scnt++; last_tx = cdc_tx; end
        if (mem_req && mem_we) wcnt++;
        if (mem_req && !mem_we) rcnt++;
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // bench model state
    logic [15:0] m_base, m_first, m_last, m_ptr, m_disp, m_iw;
    logic [7:0]  m_olo;
    bit m_run = 0, m_stop = 0, m_phase = 0, m_fresh = 0, m_hdr_mod = 0;

    function automatic logic [9:0] ix(logic [15:0] a);
        return a[9:0];
    endfunction

    function automatic logic [15:0] next_ptr(logic [15:0] p, logic [15:0] f, logic [15:0] l);
        return (p == l) ? f : p + 16'd1;
    endfunction

    task automatic poke(logic [15:0] a, logic [15:0] d);
        @(negedge clk); bw_en = 1; bw_addr = a[9:0]; bw_data = d;
        @(negedge clk); bw_en = 0;
    endtask

    task automatic ctl(logic [15:0] a);
        @(negedge clk); ctl_wr = 1; ctl_addr = a;
        @(negedge clk); ctl_wr = 0;
    endtask

    task automatic start_run(logic [15:0] b, logic [15:0] f, logic [15:0] l,
                             logic [15:0] p, logic [15:0] d);
        int r0;
        poke(b, f); poke(b + 16'd1, l); poke(b + 16'd2, p); poke(b + 16'd3, d);
        for (int k = 0; k <= int'(l - f); k++) poke(f + b + 16'(k), 16'($urandom));
        r0 = rcnt;
        ctl(b);
        repeat (10) @(negedge clk);
        check(rcnt == r0 + 4, "R1", rcnt - r0, 4);
        m_base = b; m_first = f; m_last = l; m_ptr = p; m_disp = d;
        m_iw = 16'h0; m_phase = 0; m_run = 1; m_stop = 0; m_fresh = 1; m_hdr_mod = 0;
    endtask

    task automatic do_tick(bit rdy, logic [7:0] rx);
        int s0, w0, r0;
        logic [15:0] w, ia, exp_store;
        s0 = scnt; w0 = wcnt; r0 = rcnt;
        w = mem[ix(m_base + m_ptr)];
        ia = m_base + (m_ptr + m_disp);
        @(negedge clk); tick = 1; cdc_ready = rdy; cdc_rx = rx;
        @(negedge clk); tick = 0;
        repeat (5) @(negedge clk);
        if (m_run && m_stop) begin
            check(scnt == s0 && wcnt == w0 && rcnt == r0, "R9", scnt - s0, 0);
            m_run = 0; m_stop = 0;
        end else if (!m_run || !rdy) begin
            check(scnt == s0 && wcnt == w0 && rcnt == r0,
                  m_run ? "R10" : "R9", (scnt - s0) + (wcnt - w0), 0);
        end else if (!m_phase) begin
            check(scnt == s0 + 1 && wcnt == w0 + 1, "R12", scnt - s0, 1);
            check(last_tx == ~w[15:8], m_hdr_mod ? "R11" : "R2", last_tx, ~w[15:8]);
            exp_store = ~m_iw;
            check(mem[ix(ia)] == exp_store, m_fresh ? "R8" : "R5", mem[ix(ia)], exp_store);
            m_fresh = 0;
            m_iw = {m_iw[7:0], rx};
            m_olo = ~w[7:0];
            m_ptr = next_ptr(m_ptr, m_first, m_last);
            m_phase = 1;
        end else begin
            check(scnt == s0 + 1 && rcnt == r0, "R4", rcnt - r0, 0);
            check(last_tx == m_olo, "R4", last_tx, m_olo);
            check(mem[ix(m_base + 16'd2)] == m_ptr, "R7", mem[ix(m_base + 16'd2)], m_ptr);
            m_iw = {m_iw[7:0], rx};
            m_phase = 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(!mem_req && !cdc_strobe, "R12", {mem_req, cdc_strobe}, 0);

        // R1: misaligned non-odd control write is ignored
        ctl(16'h0102);
        repeat (6) @(negedge clk);
        do_tick(1, 8'h5A);
        check(rcnt == 0 && scnt == 0, "R1", rcnt + scnt, 0);

        // run 1: plain ring, header word 1 altered later (R11), restart ignored
        start_run(16'h0100, 16'd4, 16'd9, 16'd4, 16'h0020);
        for (int t = 0; t < 40; t++) begin
            if (t == 10) begin poke(16'h0101, 16'd5); m_hdr_mod = 1; end
            if (t == 20) ctl(16'h0200);
            do_tick($urandom_range(0, 9) != 0, 8'($urandom));
        end
        // R9: stop, then further ticks stay silent
        ctl(16'h0101); m_stop = 1;
        do_tick(1, 8'h11);
        do_tick(1, 8'h22);

        // run 2: start at last offset (R3 wrap at once), coincident buffers
        start_run(16'h0200, 16'd6, 16'd7, 16'd7, 16'h0000);
        for (int t = 0; t < 20; t++) do_tick($urandom_range(0, 5) != 0, 8'($urandom));
        ctl(16'h0203); m_stop = 1;
        do_tick(1, 8'h33);

        // run 3: displacement wraps modulo 65536 (R5)
        start_run(16'h0300, 16'h0020, 16'h0023, 16'h0021, 16'hFFF0);
        for (int t = 0; t < 16; t++) do_tick(1, 8'($urandom));
        check(m_ptr != 16'h0021 || m_phase == 0, "R3", m_ptr, 16'h0021);
        finish_run();
    end
endmodule